// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port with Error Flags

This block is an asynchronous serial transmitter and receiver that run at the same time, each with a one-byte buffer. Software programs it through a small byte-wide register bus. Frames carry a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one high stop bit. An internal divider derives a 16x oversampling tick from the system clock for eight selectable rates between 300 and 115200 baud. The `baud_en` input gates that divider, so the block can also count from a slower enable strobe.

The receiver reports four kinds of error. A start error means the line had already returned high at the middle of the start bit. A parity error means the parity bit disagrees with the data. A frame error means the stop bit was sampled low. An overrun means a byte arrived while the previous one was still unread. The RX pad and the TX pad can each be inverted on their own. In echo mode the TX pad repeats the received line level. Two one-cycle interrupt pulses mark a byte landing in the receive buffer and the transmit buffer handing its byte to the shifter.

Register offsets on `reg_addr`:
- 0: control
- 1: command
- 2: transmit data (write)
- 3: transmit status
- 4: receive data
- 5: receive status

Top module: `sio_uart`

## Requirements
- R1: After reset, control reads 0x05 and command reads 0x01. Both status registers read 0x00, and `tx_pad` is high.
- R2: Control fields are bit 7 echo, bit 6 rx enable, bit 5 tx enable, bit 4 rx invert, bit 3 tx invert and bits 2:0 rate select. Rate select values 0 to 7 mean 300, 1200, 2400, 4800, 9600, 19200, 38400 and 115200 baud. One bit lasts 16*floor(CLK_HZ/(16*rate)) clocks.
- R3: Command bit 0 selects 8 data bits (1) or 7 (0). Bit 1 enables parity. Bit 2 selects odd parity (1) or even (0). Bits 7:3 are stored and read back with no effect.
- R4: Writing transmit data sends one frame: start low, data least significant bit first, the parity bit when enabled, and stop high. Even parity makes the count of ones over data and parity even; odd parity makes it odd.
- R5: A received frame lands in the receive buffer and sets full (receive status bit 0). With 7 data bits, bit 7 of the stored byte is 0. Reading receive data clears full.
- R6: Receive status bit 4 is set when the received parity bit is wrong for the selected mode.
- R7: Receive status bit 3 is set when the stop bit samples low.
- R8: A low pulse that ends before the middle of the start bit sets receive status bit 5 and stores no byte. The next good frame clears bit 5.
- R9: If a frame completes while full is set, receive status bit 2 (overrun) is set and the old byte is kept. Writing receive status clears bit 2.
- R10: With tx enable at 0, a written byte stays buffered (transmit status bit 0 set) and the pad stays idle until tx enable is set. With rx enable at 0, incoming frames are ignored.
- R11: rx invert flips the RX pad level before decoding, and tx invert flips the TX pad level. Each works on its own.
- R12: In echo mode `tx_pad` follows the decoded RX level, after tx invert, within four clocks.
- R13: `irq_rx_full` pulses for one clock per byte stored. `irq_tx_empty` pulses for one clock when the transmit buffer hands its byte to the shifter.
- R14: Transmit status bit 1 and receive status bit 1 read 1 while a frame is being sent or received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_en | input | 1 | Count enable for the rate divider (tie high to count every clock) |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears full on a receive-data read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rx_pad | input | 1 | Serial input pad |
| tx_pad | output | 1 | Serial output pad |
| irq_rx_full | output | 1 | Pulse: byte stored in the receive buffer |
| irq_tx_empty | output | 1 | Pulse: transmit buffer emptied into the shifter |

## Verification
The hardest states to reach are the receiver error states that depend on timing within one bit. A start error needs a low pulse that ends before the mid-bit sample. An overrun needs a second frame to finish while the first byte is still unread. The bench reaches the first by driving a low glitch of a quarter bit. It reaches the second by sending two frames back to back without reading the buffer. For the frame error it holds the stop bit low for three quarters of a bit, so the mid-stop sample is low. The pad inversion cases need the idle level to be changed while the receiver is disabled, so that no false start edge is seen.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} frame_st_e;

   localparam int unsigned N_RATES = 8;
   localparam int unsigned OVS     = 16;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_CMD  = 3'd1;
   localparam logic [2:0] A_TXD  = 3'd2;
   localparam logic [2:0] A_TXS  = 3'd3;
   localparam logic [2:0] A_RXD  = 3'd4;
   localparam logic [2:0] A_RXS  = 3'd5;

   function automatic int unsigned rate_of(input int unsigned sel);
      case (sel)
         0: return 300;
         1: return 1200;
         2: return 2400;
         3: return 4800;
         4: return 9600;
         5: return 19200;
         6: return 38400;
         default: return 115200;
      endcase
   endfunction

   function automatic int unsigned div_of(input int unsigned clk_hz, input int unsigned sel);
      int unsigned d;
      d = clk_hz / (OVS * rate_of(sel));
      if (d == 0) d = 1;
      return d;
   endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
   parameter int unsigned CLK_HZ = 18_432_000,
   parameter int unsigned DIV_W  = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cnt_en,
   input  logic [2:0] sel,
   output logic       tick
);
   logic [DIV_W-1:0] div_tab [sio_pkg::N_RATES];
   logic [DIV_W-1:0] cnt;

   for (genvar g = 0; g < sio_pkg::N_RATES; g++) begin : g_rate
      localparam int unsigned DV = sio_pkg::div_of(CLK_HZ, g);
      assign div_tab[g] = DIV_W'(DV - 1);
   end

   initial begin
      p_div_fits_r2: assert (sio_pkg::div_of(CLK_HZ, 0) <= (1 << DIV_W))
         else $error("divider width too small for slowest rate");
   end

   assign tick = cnt_en && (cnt >= div_tab[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (cnt_en) begin
         if (cnt >= div_tab[sel]) cnt <= '0;
         else cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sio_tx.sv
module sio_tx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       wl8,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       have_data,
   input  logic [7:0] data,
   output logic       take,
   output logic       line,
   output logic       busy
);
   import sio_pkg::*;
   frame_st_e  st;
   logic [3:0] tcnt;
   logic [2:0] bcnt;
   logic [7:0] sh;
   logic       pbit;
   logic       bit_end;
   logic       last_bit;
   logic [7:0] masked;

   assign bit_end  = tick && (tcnt == 4'hF);
   assign last_bit = (bcnt == (wl8 ? 3'd7 : 3'd6));
   assign take     = (st == ST_IDLE) && en && have_data && tick;
   assign busy     = (st != ST_IDLE);
   assign masked   = wl8 ? data : {1'b0, data[6:0]};

   always_comb begin
      case (st)
         ST_START: line = 1'b0;
         ST_DATA:  line = sh[0];
         ST_PAR:   line = pbit;
         default:  line = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         tcnt <= '0;
         bcnt <= '0;
         sh   <= '0;
         pbit <= 1'b0;
      end else begin
         if (st != ST_IDLE && tick) tcnt <= tcnt + 4'd1;
         case (st)
            ST_IDLE: if (take) begin
               sh   <= masked;
               pbit <= (^masked) ^ par_odd;
               tcnt <= '0;
               st   <= ST_START;
            end
            ST_START: if (bit_end) begin
               bcnt <= '0;
               st   <= ST_DATA;
            end
            ST_DATA: if (bit_end) begin
               sh   <= {1'b0, sh[7:1]};
               bcnt <= bcnt + 3'd1;
               if (last_bit) st <= par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR:  if (bit_end) st <= ST_STOP;
            ST_STOP: if (bit_end) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_txen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !en) |=> (st == ST_IDLE));
   p_take_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);
   p_stop_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |=> (st == ST_STOP || st == ST_IDLE));
endmodule

// File: rtl/sio_rx.sv
module sio_rx (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       wl8,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       line,
   output logic       done,
   output logic [7:0] dout,
   output logic       perr,
   output logic       ferr,
   output logic       serr_evt,
   output logic       busy
);
   import sio_pkg::*;
   frame_st_e  st;
   logic [3:0] tcnt;
   logic [2:0] bcnt;
   logic [7:0] sh;
   logic       pbit_q;
   logic       bit_end;
   logic       last_bit;
   logic [7:0] word;

   assign bit_end  = tick && (tcnt == 4'hF);
   assign last_bit = (bcnt == (wl8 ? 3'd7 : 3'd6));
   assign busy     = (st != ST_IDLE);
   assign word     = wl8 ? sh : {1'b0, sh[7:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         tcnt     <= '0;
         bcnt     <= '0;
         sh       <= '0;
         pbit_q   <= 1'b0;
         done     <= 1'b0;
         dout     <= '0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
         serr_evt <= 1'b0;
      end else begin
         done     <= 1'b0;
         serr_evt <= 1'b0;
         if (st != ST_IDLE && tick) tcnt <= tcnt + 4'd1;
         if (!en) st <= ST_IDLE;
         else begin
            case (st)
               ST_IDLE: if (!line) begin
                  tcnt <= '0;
                  st   <= ST_START;
               end
               ST_START: if (tick && tcnt == 4'd7) begin
                  if (line) begin
                     serr_evt <= 1'b1;
                     st       <= ST_IDLE;
                  end else begin
                     tcnt <= '0;
                     bcnt <= '0;
                     st   <= ST_DATA;
                  end
               end
               ST_DATA: if (bit_end) begin
                  sh   <= {line, sh[7:1]};
                  bcnt <= bcnt + 3'd1;
                  if (last_bit) st <= par_en ? ST_PAR : ST_STOP;
               end
               ST_PAR: if (bit_end) begin
                  pbit_q <= line;
                  st     <= ST_STOP;
               end
               ST_STOP: if (bit_end) begin
                  done <= 1'b1;
                  dout <= word;
                  perr <= par_en && (pbit_q != ((^word) ^ par_odd));
                  ferr <= !line;
                  st   <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   p_serr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      serr_evt |-> !done);
   p_rx_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (st == ST_IDLE));
endmodule

// File: rtl/sio_uart.sv
module sio_uart #(
   parameter int unsigned CLK_HZ = 18_432_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_en,
   input  logic [2:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       rx_pad,
   output logic       tx_pad,
   output logic       irq_rx_full,
   output logic       irq_tx_empty
);
   import sio_pkg::*;
   localparam int unsigned DIV_W = $clog2(div_of(CLK_HZ, 0) + 1);

   initial begin
      p_clk_fast_r2: assert (CLK_HZ >= OVS * 115200)
         else $error("clock too slow for the fastest rate");
   end

   logic [7:0] ctrl, cmd, tx_buf, rx_buf;
   logic       tx_full, rx_full, serr, perr, ferr, oerr, irq_rx;
   logic       rx_s1, rx_s2, rx_line;
   logic       tick, take, tx_line, tx_busy;
   logic       rx_done, rx_perr, rx_ferr, rx_serr, rx_busy;
   logic [7:0] rx_dout;
   logic       rd_rx, wr_rxs, ovr_set;

   wire c_echo  = ctrl[7];
   wire c_rxen  = ctrl[6];
   wire c_txen  = ctrl[5];
   wire c_rxinv = ctrl[4];
   wire c_txinv = ctrl[3];

   assign rd_rx   = reg_rd && (reg_addr == A_RXD);
   assign wr_rxs  = reg_wr && (reg_addr == A_RXS);
   assign ovr_set = rx_done && rx_full && !rd_rx;
   assign rx_line = rx_s2 ^ c_rxinv;
   assign tx_pad  = (c_echo ? rx_line : tx_line) ^ c_txinv;
   assign irq_rx_full  = irq_rx;
   assign irq_tx_empty = take;

   sio_baud #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .cnt_en(baud_en), .sel(ctrl[2:0]), .tick(tick));

   sio_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(c_txen), .wl8(cmd[0]),
      .par_en(cmd[1]), .par_odd(cmd[2]), .have_data(tx_full), .data(tx_buf),
      .take(take), .line(tx_line), .busy(tx_busy));

   sio_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(c_rxen), .wl8(cmd[0]),
      .par_en(cmd[1]), .par_odd(cmd[2]), .line(rx_line), .done(rx_done),
      .dout(rx_dout), .perr(rx_perr), .ferr(rx_ferr), .serr_evt(rx_serr),
      .busy(rx_busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_s1 <= 1'b1;
         rx_s2 <= 1'b1;
      end else begin
         rx_s1 <= rx_pad;
         rx_s2 <= rx_s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= 8'h05;
         cmd     <= 8'h01;
         tx_buf  <= '0;
         tx_full <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_CTRL) ctrl <= reg_wdata;
         if (reg_wr && reg_addr == A_CMD)  cmd  <= reg_wdata;
         if (reg_wr && reg_addr == A_TXD) begin
            tx_buf  <= reg_wdata;
            tx_full <= 1'b1;
         end else if (take) tx_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         rx_full <= 1'b0;
         serr    <= 1'b0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
         oerr    <= 1'b0;
         irq_rx  <= 1'b0;
      end else begin
         irq_rx <= 1'b0;
         if (ovr_set) oerr <= 1'b1;
         else if (wr_rxs) oerr <= 1'b0;
         if (rx_done && !ovr_set) begin
            rx_buf  <= rx_dout;
            perr    <= rx_perr;
            ferr    <= rx_ferr;
            serr    <= 1'b0;
            rx_full <= 1'b1;
            irq_rx  <= 1'b1;
         end else if (rd_rx) rx_full <= 1'b0;
         if (rx_serr) serr <= 1'b1;
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = ctrl;
         A_CMD:   reg_rdata = cmd;
         A_TXS:   reg_rdata = {6'b0, tx_busy, tx_full};
         A_RXD:   reg_rdata = rx_buf;
         A_RXS:   reg_rdata = {2'b0, serr, perr, ferr, oerr, rx_busy, rx_full};
         default: reg_rdata = 8'h00;
      endcase
   end

   p_irq_rx_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |=> !irq_rx);
   p_overrun_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_set |=> ($stable(rx_buf) && oerr));
   p_oerr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rxs && !ovr_set) |=> !oerr);
   p_full_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !rx_done) |=> !rx_full);
endmodule

// File: tb/sio_uart_tb.sv
module sio_uart_tb;
   localparam int unsigned CLK_HZ = 3_686_400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       rx_pad = 1'b1;
   logic       tx_pad, irq_rx_full, irq_tx_empty;
   int checks = 0, errors = 0, n_irx = 0, n_itx = 0;

   always #2.5 clk = ~clk;

   sio_uart #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .baud_en(1'b1), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rx_pad(rx_pad), .tx_pad(tx_pad),
      .irq_rx_full(irq_rx_full), .irq_tx_empty(irq_tx_empty));

   always @(negedge clk) begin
      if (irq_rx_full) n_irx++;
      if (irq_tx_empty) n_itx++;
   end

   // sel[13:11] wl8[10] pe[9] odd[8] data[7:0]
   localparam logic [13:0] VEC [6] = '{
      {3'd7, 1'b1, 1'b0, 1'b0, 8'hA5},
      {3'd7, 1'b0, 1'b1, 1'b0, 8'h53},
      {3'd6, 1'b1, 1'b1, 1'b1, 8'h3C},
      {3'd5, 1'b0, 1'b0, 1'b0, 8'h7F},
      {3'd4, 1'b1, 1'b1, 1'b0, 8'h01},
      {3'd3, 1'b1, 1'b1, 1'b1, 8'hFE}};

   function automatic int bit_period(input int sel);
      int r;
      case (sel)
         0: r = 300; 1: r = 1200; 2: r = 2400; 3: r = 4800;
         4: r = 9600; 5: r = 19200; 6: r = 38400; default: r = 115200;
      endcase
      return 16 * (CLK_HZ / (16 * r));
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic recv_tx(input int p, input bit wl8, input bit pe, input bit inv,
                          output logic [7:0] d, output bit pb, output bit sb, output bit ok);
      int w = 0;
      d = '0; pb = 1'b0; sb = 1'b0;
      while (tx_pad !== inv && w < 40 * p) begin @(negedge clk); w++; end
      ok = (w < 40 * p);
      repeat (p / 2) @(negedge clk);
      for (int i = 0; i < (wl8 ? 8 : 7); i++) begin
         repeat (p) @(negedge clk);
         d[i] = tx_pad ^ inv;
      end
      if (pe) begin repeat (p) @(negedge clk); pb = tx_pad ^ inv; end
      repeat (p) @(negedge clk);
      sb = tx_pad ^ inv;
      repeat (p) @(negedge clk);
   endtask

   task automatic send_rx(input int p, input bit wl8, input bit pe, input bit odd,
                          input logic [7:0] d, input bit bad_par, input bit bad_stop,
                          input bit inv);
      logic [7:0] m;
      m = wl8 ? d : {1'b0, d[6:0]};
      @(negedge clk);
      rx_pad = inv;
      repeat (p) @(negedge clk);
      for (int i = 0; i < (wl8 ? 8 : 7); i++) begin
         rx_pad = m[i] ^ inv;
         repeat (p) @(negedge clk);
      end
      if (pe) begin
         rx_pad = ((^m) ^ odd ^ bad_par) ^ inv;
         repeat (p) @(negedge clk);
      end
      if (bad_stop) begin
         rx_pad = inv;
         repeat (3 * p / 4) @(negedge clk);
      end else begin
         rx_pad = ~inv;
         repeat (p) @(negedge clk);
      end
      rx_pad = ~inv;
      repeat (p) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v, d, m;
      bit pb, sb, ok, lowseen;
      int p, i0, t0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx idle", tx_pad, 1);
      rd(3'd0, v); chk("R1 ctrl", v, 8'h05);
      rd(3'd1, v); chk("R1 cmd", v, 8'h01);
      rd(3'd3, v); chk("R1 txs", v, 8'h00);
      rd(3'd5, v); chk("R1 rxs", v, 8'h00);

      wr(3'd1, 8'hF9); rd(3'd1, v); chk("R3 cmd upper bits", v, 8'hF9);
      wr(3'd1, 8'h01);

      // table of frames: transmit and receive each entry
      for (int k = 0; k < 6; k++) begin
         automatic logic [2:0] sel = VEC[k][13:11];
         automatic bit wl8 = VEC[k][10], pe = VEC[k][9], odd = VEC[k][8];
         p = bit_period(sel);
         m = wl8 ? VEC[k][7:0] : {1'b0, VEC[k][6:0]};
         wr(3'd0, {5'b01100, sel});
         wr(3'd1, {5'b0, odd, pe, wl8});
         t0 = n_itx;
         wr(3'd2, VEC[k][7:0]);
         recv_tx(p, wl8, pe, 1'b0, d, pb, sb, ok);
         chk("R4 start seen", ok, 1);
         chk("R2 R4 tx data", d, m);
         if (pe) chk("R4 tx parity", pb, (^m) ^ odd);
         chk("R4 tx stop", sb, 1);
         chk("R13 tx irq", n_itx - t0, 1);
         i0 = n_irx;
         send_rx(p, wl8, pe, odd, VEC[k][7:0], 1'b0, 1'b0, 1'b0);
         rd(3'd5, v); chk("R5 rxs full", v, 8'h01);
         rd(3'd4, v); chk("R5 rx data", v, m);
         rd(3'd5, v); chk("R5 full cleared", v, 8'h00);
         chk("R13 rx irq", n_irx - i0, 1);
      end

      // busy flags
      p = bit_period(7);
      wr(3'd0, 8'h67); wr(3'd1, 8'h01);
      wr(3'd2, 8'h11);
      repeat (3 * p) @(negedge clk);
      rd(3'd3, v); chk("R14 tx busy", v, 8'h02);
      repeat (12 * p) @(negedge clk);
      rd(3'd3, v); chk("R14 tx done", v, 8'h00);
      fork
         send_rx(p, 1'b1, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0);
         begin repeat (3 * p) @(negedge clk); rd(3'd5, v); chk("R14 rx busy", v[1], 1); end
      join
      rd(3'd4, v);

      // parity error
      wr(3'd1, 8'h03);
      send_rx(p, 1'b1, 1'b1, 1'b0, 8'h6B, 1'b1, 1'b0, 1'b0);
      rd(3'd5, v); chk("R6 perr", v[4], 1); chk("R6 full", v[0], 1);
      rd(3'd4, v); chk("R6 data", v, 8'h6B);

      // frame error
      wr(3'd1, 8'h01);
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'h99, 1'b0, 1'b1, 1'b0);
      repeat (p) @(negedge clk);
      rd(3'd5, v); chk("R7 ferr", v[3], 1); chk("R7 perr clear", v[4], 0);
      rd(3'd4, v); chk("R7 data", v, 8'h99);

      // start error
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0);
      rd(3'd5, v); chk("R8 serr cleared by good frame", v[5], 0);
      rd(3'd4, v);
      i0 = n_irx;
      @(negedge clk); rx_pad = 1'b0;
      repeat (p / 4) @(negedge clk);
      rx_pad = 1'b1;
      repeat (2 * p) @(negedge clk);
      rd(3'd5, v); chk("R8 serr", v[5], 1); chk("R8 no byte", v[0], 0);
      chk("R8 no irq", n_irx - i0, 0);

      // overrun
      i0 = n_irx;
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0, 1'b0);
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'h42, 1'b0, 1'b0, 1'b0);
      rd(3'd5, v); chk("R9 oerr", v[2], 1); chk("R9 full", v[0], 1);
      chk("R13 one irq on overrun", n_irx - i0, 1);
      rd(3'd4, v); chk("R9 old byte kept", v, 8'h41);
      wr(3'd5, 8'h00);
      rd(3'd5, v); chk("R9 oerr cleared", v[2], 0);

      // enables
      wr(3'd0, 8'h47);
      wr(3'd2, 8'h5A);
      lowseen = 1'b0;
      for (int c = 0; c < 20 * p; c++) begin @(negedge clk); if (!tx_pad) lowseen = 1'b1; end
      chk("R10 tx held idle", lowseen, 0);
      rd(3'd3, v); chk("R10 tx buffered", v, 8'h01);
      wr(3'd0, 8'h67);
      recv_tx(p, 1'b1, 1'b0, 1'b0, d, pb, sb, ok);
      chk("R10 tx after enable", d, 8'h5A);
      wr(3'd0, 8'h27);
      i0 = n_irx;
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0);
      rd(3'd5, v); chk("R10 rx disabled", v[0], 0);
      chk("R10 rx disabled irq", n_irx - i0, 0);

      // inversion: tx only, then both
      wr(3'd0, 8'h2F);
      repeat (4) @(negedge clk);
      chk("R11 tx invert idle", tx_pad, 0);
      wr(3'd0, 8'h6F);
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'hB4, 1'b0, 1'b0, 1'b0);
      rd(3'd4, v); chk("R11 rx plain with tx invert", v, 8'hB4);
      wr(3'd0, 8'h3F);
      rx_pad = 1'b0;
      wr(3'd0, 8'h7F);
      wr(3'd2, 8'hC3);
      recv_tx(p, 1'b1, 1'b0, 1'b1, d, pb, sb, ok);
      chk("R11 tx inverted frame", d, 8'hC3);
      send_rx(p, 1'b1, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b1);
      rd(3'd4, v); chk("R11 rx inverted frame", v, 8'h96);

      // echo
      wr(3'd0, 8'h07);
      rx_pad = 1'b1;
      wr(3'd0, 8'h87);
      rx_pad = 1'b0; repeat (4) @(negedge clk);
      chk("R12 echo low", tx_pad, 0);
      rx_pad = 1'b1; repeat (4) @(negedge clk);
      chk("R12 echo high", tx_pad, 1);
      wr(3'd0, 8'h8F);
      rx_pad = 1'b0; repeat (4) @(negedge clk);
      chk("R12 echo with tx invert", tx_pad, 1);
      rx_pad = 1'b1;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule